// File: doc/BRIEF.md
# Mailbox Event Interrupt Controller (single user)

This block collects the interrupt events of a group of mailboxes on behalf of one user and folds them into one interrupt line. Each mailbox supplies two live conditions: "a message is waiting" and "the queue can take another message". Each condition is latched into a sticky raw status bit. An enable vector selects which raw bits reach the interrupt line. The masked status (raw AND enable) is reduced by OR and drives the interrupt output, which is registered by default.

Software reaches the block over a small single-cycle register bus. The bus has a write strobe, a word address, write data and combinational read data. Four word addresses are decoded. Address 0 is the raw status: a read returns the latched events, and writing a 1 forces that event pending as a debug aid. Address 1 is the masked status: a read returns raw AND enable, and writing a 1 clears that raw bit. Address 2 is the enable set port: writing a 1 sets that enable. Address 3 is the enable clear port: writing a 1 clears that enable. A read of either enable port returns the current enable vector.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: For mailbox m, event bit 2m latches `msg_pending[m]` and bit 2m+1 latches `has_room[m]`; a condition that is high at a clock edge shows in the raw status (address 0) after that edge.
- R2: A raw status bit stays 1 after its condition drops until software clears it.
- R3: Writing 1 to a bit at address 1 clears that raw bit at the write edge. If the condition is still high, the bit reads 0 for one cycle and is 1 again after the next edge. Writing 0 leaves the bit unchanged.
- R4: Writing 1 to a bit at address 0 forces that raw bit to 1. Writing 0 leaves the bit unchanged.
- R5: Writing 1 to a bit at address 2 sets that enable bit. Writing 0 leaves it unchanged.
- R6: Writing 1 to a bit at address 3 clears that enable bit. Writing 0 leaves it unchanged.
- R7: After reset, with all conditions low, the raw status, the enables and `irq_o` are all 0.
- R8: A read of address 1 returns raw AND enable. A read of address 2 or address 3 returns the enable vector.
- R9: `irq_o` is 1 exactly one cycle after any masked status bit is 1, and is 0 one cycle after the masked status becomes all-zero.
- R10: Bits 31..24 read as 0 and ignore writes. Addresses 4 and above read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_pending | input | 12 | Per mailbox: a message is waiting |
| has_room | input | 12 | Per mailbox: the queue is not full |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt line to the user |

## Verification
The bound checker watches four rules on every cycle. Bits that were set and not cleared stay set. Live conditions always land in the raw status. Enable set and clear writes take effect at the write edge. The interrupt line follows the OR of the masked status with one cycle of latency. The checker also confirms that the reserved upper bits read 0 and that masked reads return raw AND enable. Several behaviours are shown only by the bench's scenarios. These are the interleaved mapping of each mailbox's two events, the one-cycle dip after clearing a bit whose condition is still high, forced debug events, writes of zero that must change nothing, and reads of unmapped addresses.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
   typedef enum logic [1:0] {
      REG_RAW    = 2'd0,
      REG_MASKED = 2'd1,
      REG_EN_SET = 2'd2,
      REG_EN_CLR = 2'd3
   } reg_sel_e;
   localparam int unsigned NUM_REGS = 4;
endpackage

// File: rtl/mbx_evt_map.sv
module mbx_evt_map #(
   parameter int unsigned NUM_BOX = 12,
   localparam int unsigned EVT_W = 2 * NUM_BOX
) (
   input  logic [NUM_BOX-1:0] msg_pending,
   input  logic [NUM_BOX-1:0] has_room,
   output logic [EVT_W-1:0]   evt_vec
);
   for (genvar m = 0; m < NUM_BOX; m++) begin : g_box
      assign evt_vec[2*m]   = msg_pending[m];
      assign evt_vec[2*m+1] = has_room[m];
   end
endmodule

// File: rtl/mbx_evt_status.sv
module mbx_evt_status #(
   parameter int unsigned EVT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] hw_evt,
   input  logic [EVT_W-1:0] force_mask,
   input  logic [EVT_W-1:0] clear_mask,
   output logic [EVT_W-1:0] raw_q
);
   logic [EVT_W-1:0] raw_d;

   // a clear wins for one cycle; a live condition re-latches afterwards
   always_comb raw_d = ~clear_mask & (raw_q | hw_evt | force_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= raw_d;
   end
endmodule

// File: rtl/mbx_irq_enable.sv
module mbx_irq_enable #(
   parameter int unsigned EVT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] set_mask,
   input  logic [EVT_W-1:0] clr_mask,
   output logic [EVT_W-1:0] en_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= (en_q | set_mask) & ~clr_mask;
   end
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
   import mbx_irq_pkg::*;
#(
   parameter int unsigned NUM_BOX = 12,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_BOX-1:0] msg_pending,
   input  logic [NUM_BOX-1:0] has_room,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_o
);
   localparam int unsigned EVT_W = 2 * NUM_BOX;

   initial begin
      assert (EVT_W < DATA_W) else $error("event vector must leave reserved bits");
      assert (ADDR_W >= 2) else $error("address too narrow for register set");
   end

   logic [EVT_W-1:0] hw_evt, raw_q, en_q, masked;
   logic [EVT_W-1:0] wr_bits, force_mask, clr_raw, en_set, en_clr, rd_evt;
   logic             addr_ok;
   reg_sel_e         sel;
   logic             unused_hi;

   assign addr_ok   = (bus_addr < ADDR_W'(NUM_REGS));
   assign sel       = reg_sel_e'(bus_addr[1:0]);
   assign wr_bits   = bus_wdata[EVT_W-1:0];
   assign unused_hi = ^bus_wdata[DATA_W-1:EVT_W];

   always_comb begin
      force_mask = '0;
      clr_raw    = '0;
      en_set     = '0;
      en_clr     = '0;
      if (bus_wr && addr_ok) begin
         unique case (sel)
            REG_RAW:    force_mask = wr_bits;
            REG_MASKED: clr_raw    = wr_bits;
            REG_EN_SET: en_set     = wr_bits;
            REG_EN_CLR: en_clr     = wr_bits;
         endcase
      end
   end

   mbx_evt_map #(.NUM_BOX(NUM_BOX)) i_map (
      .msg_pending(msg_pending), .has_room(has_room), .evt_vec(hw_evt));

   mbx_evt_status #(.EVT_W(EVT_W)) i_status (
      .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .force_mask(force_mask),
      .clear_mask(clr_raw), .raw_q(raw_q));

   mbx_irq_enable #(.EVT_W(EVT_W)) i_enable (
      .clk(clk), .rst_n(rst_n), .set_mask(en_set), .clr_mask(en_clr), .en_q(en_q));

   assign masked = raw_q & en_q;

   always_comb begin
      rd_evt = '0;
      if (addr_ok) begin
         unique case (sel)
            REG_RAW:    rd_evt = raw_q;
            REG_MASKED: rd_evt = masked;
            REG_EN_SET,
            REG_EN_CLR: rd_evt = en_q;
         endcase
      end
   end
   assign bus_rdata = DATA_W'(rd_evt);

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= |masked;
      end
   end else begin : g_irq_comb
      assign irq_o = |masked;
   end
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
   parameter int unsigned NUM_BOX = 12,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter bit          IRQ_REG = 1'b1,
   localparam int unsigned EVT_W = 2 * NUM_BOX
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_BOX-1:0] msg_pending,
   input logic [NUM_BOX-1:0] has_room,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               irq_o,
   input logic [EVT_W-1:0]   raw_q,
   input logic [EVT_W-1:0]   en_q
);
   logic [EVT_W-1:0] cond, clr_w, keep, live, set_w, enc_w;

   always_comb begin
      for (int m = 0; m < int'(NUM_BOX); m++) begin
         cond[2*m]   = msg_pending[m];
         cond[2*m+1] = has_room[m];
      end
   end

   assign clr_w = (bus_wr && bus_addr == ADDR_W'(1)) ? bus_wdata[EVT_W-1:0] : '0;
   assign set_w = (bus_wr && bus_addr == ADDR_W'(2)) ? bus_wdata[EVT_W-1:0] : '0;
   assign enc_w = (bus_wr && bus_addr == ADDR_W'(3)) ? bus_wdata[EVT_W-1:0] : '0;
   assign keep  = raw_q & ~clr_w;
   assign live  = cond & ~clr_w;

   AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw_q & $past(keep)) == $past(keep)));                           // R2
   AST_COND_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw_q & $past(live)) == $past(live)));                           // R1
   AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_w) |=> ((en_q & $past(set_w)) == $past(set_w)));                      // R5
   AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (|enc_w) |=> ((en_q & $past(enc_w)) == '0));                                // R6
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:EVT_W] == '0);                                           // R10
   AST_MASKED_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(1)) |-> (bus_rdata[EVT_W-1:0] == (raw_q & en_q)));      // R8

   if (IRQ_REG) begin : g_irq_chk
      AST_IRQ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq_o == $past(|(raw_q & en_q))));                             // R9
   end
endmodule

bind mbx_irq_ctrl mbx_irq_chk #(
   .NUM_BOX(NUM_BOX), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IRQ_REG(IRQ_REG)
) i_mbx_irq_chk (
   .clk(clk), .rst_n(rst_n), .msg_pending(msg_pending), .has_room(has_room),
   .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata), .irq_o(irq_o), .raw_q(raw_q), .en_q(en_q));

// File: tb/test_mbx_irq_ctrl.sv
module test_mbx_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB-1:0] msg_pending = '0;
   logic [NB-1:0] has_room = '0;
   logic          bus_wr = 1'b0;
   logic [3:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbx_irq_ctrl i_mbx_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .msg_pending(msg_pending), .has_room(has_room),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(4'd0, v); check("R7 raw", v, 32'h0);
      rd(4'd2, v); check("R7 enable", v, 32'h0);
      check("R7 irq", {31'h0, irq_o}, 32'h0);

      // R1/R2/R3 sweep: each mailbox, both event kinds
      for (int m = 0; m < NB; m++) begin
         for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            if (k == 0) msg_pending = NB'(1) << m; else has_room = NB'(1) << m;
            @(negedge clk);
            msg_pending = '0; has_room = '0;
            @(negedge clk);
            rd(4'd0, v); check("R1/R2 latched bit", v, 32'h1 << (2*m + k));
            wr(4'd1, 32'h0);
            rd(4'd0, v); check("R3 zero write keeps", v, 32'h1 << (2*m + k));
            wr(4'd1, 32'hFFFF_FFFF);
            rd(4'd0, v); check("R3 cleared", v, 32'h0);
         end
      end

      // R3: clear while condition still high
      @(negedge clk); msg_pending[3] = 1'b1;
      @(negedge clk);
      wr(4'd1, 32'h40);
      rd(4'd0, v); check("R3 dip", v & 32'h40, 32'h0);
      @(negedge clk);
      rd(4'd0, v); check("R3 relatch", v & 32'h40, 32'h40);
      msg_pending = '0;
      wr(4'd1, 32'hFF_FFFF);

      // R4 / R10 force
      wr(4'd0, 32'h0);
      rd(4'd0, v); check("R4 zero force", v, 32'h0);
      wr(4'd0, 32'hFF12_3456);
      rd(4'd0, v); check("R4/R10 force", v, 32'h0012_3456);
      wr(4'd1, 32'hFF_FFFF);

      // R5 / R6 / R8 / R10 enables
      wr(4'd2, 32'h0000_0F0F);
      rd(4'd2, v); check("R5 set", v, 32'h0F0F);
      rd(4'd3, v); check("R8 clr port reads enable", v, 32'h0F0F);
      wr(4'd2, 32'h0);
      rd(4'd2, v); check("R5 zero write", v, 32'h0F0F);
      wr(4'd2, 32'hFF00_0000);
      rd(4'd2, v); check("R10 reserved set", v, 32'h0F0F);
      wr(4'd3, 32'h0000_0F00);
      rd(4'd3, v); check("R6 clear", v, 32'h000F);
      wr(4'd3, 32'h0);
      rd(4'd2, v); check("R6 zero write", v, 32'h000F);

      // R8 / R9 masking and irq latency
      wr(4'd0, 32'h0000_00F0);
      rd(4'd1, v); check("R8 masked none", v, 32'h0);
      @(negedge clk);
      check("R9 masked-off irq", {31'h0, irq_o}, 32'h0);
      wr(4'd0, 32'h0000_0002);
      rd(4'd1, v); check("R8 masked", v, 32'h2);
      check("R9 irq not yet", {31'h0, irq_o}, 32'h0);
      @(negedge clk);
      check("R9 irq raised", {31'h0, irq_o}, 32'h1);
      wr(4'd1, 32'h0000_0002);
      check("R9 irq still high", {31'h0, irq_o}, 32'h1);
      @(negedge clk);
      check("R9 irq dropped", {31'h0, irq_o}, 32'h0);
      rd(4'd0, v); check("R3 masked clear", v, 32'h0F0);

      // R10 unmapped addresses
      for (int a = 4; a < 16; a++) begin
         rd(4'(a), v); check("R10 unmapped", v, 32'h0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule